// File: doc/BRIEF.md
# Two-Buffer Write-Combining Store Queue

The block holds sixteen 32-bit longwords split into two buffers of eight. Software fills either buffer with single-longword writes, can read any longword back, and then issues a flush command whose address picks one buffer. The flush sends all 32 bytes of that buffer to external memory as one burst write, together with a line-aligned target address. Protection checks and address translation are done before requests reach the block.

The target address is formed in one of two ways, chosen by a mode input. When the flush address is untranslated, the line offset within a 64 MiB window comes from the flush address, and three high bits come from a per-buffer queue-address control input. When the address is already translated, it is used as is, masked to a 29-bit line-aligned physical address.

Only one burst is outstanding at a time. While it waits for its acknowledge, the block reports busy, drops new flush commands, and stalls writes aimed at the buffer being sent. Writes to the other buffer go ahead.

Top module: `store_combiner`

## Requirements
- R1: After reset, `busy`, `bst_valid` and `acc_stall` are 0, every stored longword reads back as 0, and `acc_rdata` is 0.
- R2: A write stores `acc_wdata` in longword `acc_addr[5:2]`. A read of longword `acc_addr[5:2]` shows its value on `acc_rdata` from the clock edge that samples the read. Longwords 0-7 form buffer 0 and longwords 8-15 form buffer 1.
- R3: A flush sends the buffer selected by `flush_addr[5]`. Longword k of that buffer (k = 0..7) appears on `bst_data[32k+31:32k]`.
- R4: When `xlat_mode` is 0, `bst_addr[25:5]` equals `flush_addr[25:5]`. `bst_addr[28:26]` equals bits [4:2] of `qaddr0` for buffer 0, or of `qaddr1` for buffer 1. `bst_addr[31:29]` and `bst_addr[4:0]` are 0.
- R5: When `xlat_mode` is 1, `bst_addr` equals `flush_addr & 32'h1FFFFFE0`, and the queue-address inputs have no effect.
- R6: A flush accepted at a clock edge raises `busy` and `bst_valid` from that edge. They stay high, with `bst_addr` and `bst_data` unchanged, until an edge that samples `bst_ack` high; they are low after that edge.
- R7: A flush request while `busy` is high is dropped. It does not change the outstanding burst and does not cause a second burst.
- R8: While a burst is outstanding, a write to the buffer being sent raises `acc_stall` in the same cycle and is not stored. A write to the other buffer is stored without a stall.
- R9: Bits of `qaddr0` and `qaddr1` other than [4:2] have no effect on `bst_addr`.
- R10: A write to a buffer in the same cycle that a flush of that buffer is accepted is stored and is included in the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Longword access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address; bits [5:2] pick the longword |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered |
| acc_stall | output | 1 | Write blocked by an outstanding burst |
| flush_req | input | 1 | Flush command |
| flush_addr | input | 32 | Flush address; bit 5 picks the buffer |
| xlat_mode | input | 1 | 1 = flush address is already translated |
| qaddr0 | input | 32 | Queue-address control for buffer 0 |
| qaddr1 | input | 32 | Queue-address control for buffer 1 |
| busy | output | 1 | A burst is outstanding |
| bst_valid | output | 1 | Burst write request |
| bst_addr | output | 32 | Burst target address |
| bst_data | output | 256 | Burst payload, longword 0 in the low bits |
| bst_ack | input | 1 | Burst accepted by memory |

## Verification
The assertions assume `bst_ack` is only raised while a burst is outstanding. They also assume a stalled write is not expected to land later, because the block drops it rather than holding it. The stimulus raises the acknowledge only while `bst_valid` is high. It treats a stalled write as lost and issues the write again after the acknowledge where the test needs the data. The queue-address inputs and `xlat_mode` are held steady around each flush, since the block samples them only on the edge that accepts the flush.

// File: rtl/store_combiner_pkg.sv
package store_combiner_pkg;
    localparam int SC_ADDR_W  = 32;
    localparam int SC_WORD_W  = 32;
    localparam int SC_BUF_CNT = 2;
    localparam int SC_BUF_WDS = 8;

    typedef struct packed {
        logic                 busy;
        logic [0:0]           sel;
        logic [SC_ADDR_W-1:0] tgt;
    } flush_state_t;
endpackage

// File: rtl/sc_word_store.sv
module sc_word_store #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 16,
    localparam int IDX_W  = $clog2(N_WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rdata,
    output logic [N_WORDS*WORD_W-1:0] words
);
    typedef struct packed {
        logic [N_WORDS-1:0][WORD_W-1:0] mem;
        logic [WORD_W-1:0]              rd;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.mem[idx] = wdata;
        if (rd_en) st_d.rd = st_q.mem[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rd;
    assign words = st_q.mem;

    // R2: a stored write is visible in the array after the edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> words[$past(idx)*WORD_W +: WORD_W] == $past(wdata));
endmodule

// File: rtl/sc_target_gen.sv
module sc_target_gen #(
    parameter int ADDR_W   = 32,
    parameter int BUF_CNT  = 2,
    parameter int OFF_W    = 5,
    parameter int HI_LSB   = 26,
    parameter int HI_W     = 3,
    parameter int REG_LSB  = 2,
    parameter int XLAT_TOP = 28,
    localparam int SEL_W   = $clog2(BUF_CNT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         flush_addr,
    input  logic                      xlat_mode,
    input  logic [BUF_CNT*ADDR_W-1:0] qregs,
    output logic [SEL_W-1:0]          sel,
    output logic [ADDR_W-1:0]         tgt
);
    logic [ADDR_W-1:0] qarr [BUF_CNT];

    for (genvar b = 0; b < BUF_CNT; b++) begin : g_unpack
        assign qarr[b] = qregs[b*ADDR_W +: ADDR_W];
    end

    assign sel = flush_addr[OFF_W +: SEL_W];

    logic [ADDR_W-1:0] qsel;
    assign qsel = qarr[sel];

    always_comb begin
        tgt = '0;
        if (xlat_mode) begin
            tgt[XLAT_TOP:OFF_W] = flush_addr[XLAT_TOP:OFF_W];
        end else begin
            tgt[HI_LSB-1:OFF_W]         = flush_addr[HI_LSB-1:OFF_W];
            tgt[HI_LSB+HI_W-1:HI_LSB]   = qsel[REG_LSB+HI_W-1:REG_LSB];
        end
    end

    logic unused_bits;
    assign unused_bits = ^{qsel, flush_addr};

    // R4: untranslated target is line aligned with its top bits clear
    p_untrans_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_mode |-> (tgt[OFF_W-1:0] == '0 && tgt[ADDR_W-1:HI_LSB+HI_W] == '0));
    // R5: translated target never reaches above the 29-bit window
    p_xlat_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_mode |-> (tgt[ADDR_W-1:XLAT_TOP+1] == '0 && tgt[OFF_W-1:0] == '0));
endmodule

// File: rtl/sc_flush_ctrl.sv
module sc_flush_ctrl
    import store_combiner_pkg::*;
#(
    parameter int ADDR_W = SC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              sel_in,
    input  logic [ADDR_W-1:0] tgt_in,
    input  logic              bst_ack,
    output logic              busy,
    output logic              sel_q,
    output logic [ADDR_W-1:0] tgt_q
);
    flush_state_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (fs_q.busy) begin
            if (bst_ack) fs_d.busy = 1'b0;
        end else if (flush_req) begin
            fs_d.busy = 1'b1;
            fs_d.sel  = sel_in;
            fs_d.tgt  = tgt_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign busy  = fs_q.busy;
    assign sel_q = fs_q.sel;
    assign tgt_q = fs_q.tgt;

    // R6: an unacknowledged burst keeps its request and address
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bst_ack |=> busy && $stable(tgt_q) && $stable(sel_q));
    // R6: acknowledge ends the burst
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bst_ack |=> !busy);
    // R7: busy only starts from an idle cycle with a flush request
    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !flush_req |=> !busy);
endmodule

// File: rtl/store_combiner.sv
module store_combiner
    import store_combiner_pkg::*;
#(
    parameter int ADDR_W  = SC_ADDR_W,
    parameter int WORD_W  = SC_WORD_W,
    parameter int BUF_CNT = SC_BUF_CNT,
    parameter int BUF_WDS = SC_BUF_WDS,
    localparam int N_WORDS = BUF_CNT * BUF_WDS,
    localparam int IDX_W   = $clog2(N_WORDS),
    localparam int BYTE_LSB = $clog2(WORD_W / 8),
    localparam int OFF_W   = $clog2(BUF_WDS * WORD_W / 8),
    localparam int LINE_W  = BUF_WDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic [WORD_W-1:0] acc_rdata,
    output logic              acc_stall,
    input  logic              flush_req,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              xlat_mode,
    input  logic [ADDR_W-1:0] qaddr0,
    input  logic [ADDR_W-1:0] qaddr1,
    output logic              busy,
    output logic              bst_valid,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [LINE_W-1:0] bst_data,
    input  logic              bst_ack
);
    logic [IDX_W-1:0]          idx;
    logic                      wr_en;
    logic                      rd_en;
    logic [N_WORDS*WORD_W-1:0] all_words;
    logic                      sel_new;
    logic                      sel_q;
    logic [ADDR_W-1:0]         tgt_new;

    assign idx = acc_addr[BYTE_LSB +: IDX_W];

    assign acc_stall = acc_en && acc_we && busy && (acc_addr[OFF_W] == sel_q);
    assign wr_en     = acc_en && acc_we && !acc_stall;
    assign rd_en     = acc_en && !acc_we;

    sc_word_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .idx   (idx),
        .wdata (acc_wdata),
        .rdata (acc_rdata),
        .words (all_words)
    );

    sc_target_gen #(.ADDR_W(ADDR_W), .BUF_CNT(BUF_CNT), .OFF_W(OFF_W)) u_tgt (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_addr (flush_addr),
        .xlat_mode  (xlat_mode),
        .qregs      ({qaddr1, qaddr0}),
        .sel        (sel_new),
        .tgt        (tgt_new)
    );

    sc_flush_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .sel_in    (sel_new),
        .tgt_in    (tgt_new),
        .bst_ack   (bst_ack),
        .busy      (busy),
        .sel_q     (sel_q),
        .tgt_q     (bst_addr)
    );

    assign bst_valid = busy;
    assign bst_data  = all_words[sel_q*LINE_W +: LINE_W];

    logic unused_acc;
    assign unused_acc = ^acc_addr;

    // R8: the payload cannot change while the burst waits for acknowledge
    p_payload_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bst_ack |=> $stable(bst_data));
    // R8: a stall only ever appears during an outstanding burst
    p_stall_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> bst_valid);
endmodule

// File: tb/store_combiner_test.sv
module store_combiner_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         acc_en, acc_we;
    logic [31:0]  acc_addr, acc_wdata, acc_rdata;
    logic         acc_stall;
    logic         flush_req;
    logic [31:0]  flush_addr;
    logic         xlat_mode;
    logic [31:0]  qaddr0, qaddr1;
    logic         busy, bst_valid, bst_ack;
    logic [31:0]  bst_addr;
    logic [255:0] bst_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [16];

    always #10 clk = ~clk;

    store_combiner uut (
        .clk(clk), .rst_n(rst_n),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_stall(acc_stall),
        .flush_req(flush_req), .flush_addr(flush_addr), .xlat_mode(xlat_mode),
        .qaddr0(qaddr0), .qaddr1(qaddr1),
        .busy(busy), .bst_valid(bst_valid), .bst_addr(bst_addr),
        .bst_data(bst_data), .bst_ack(bst_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_tgt(input logic [31:0] a, input logic xl);
        logic [31:0] q;
        q = a[5] ? qaddr1 : qaddr0;
        if (xl) return a & 32'h1FFFFFE0;
        return (a & 32'h03FFFFE0) | ({29'd0, q[4:2]} << 26);
    endfunction

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 0; acc_we = 0;
        model[a[5:2]] = d;
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_en = 1; acc_we = 0; acc_addr = a;
        @(negedge clk);
        acc_en = 0;
        d = acc_rdata;
    endtask

    task automatic do_flush(input logic [31:0] a);
        @(negedge clk);
        flush_req = 1; flush_addr = a;
        @(negedge clk);
        flush_req = 0;
    endtask

    task automatic do_ack;
        @(negedge clk);
        bst_ack = 1;
        @(negedge clk);
        bst_ack = 0;
    endtask

    task automatic check_payload(input string req, input int b);
        for (int k = 0; k < 8; k++)
            check(req, bst_data[32*k +: 32], model[b*8 + k]);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 bst_valid", {31'd0, bst_valid}, 0);
        check("R1 acc_stall", {31'd0, acc_stall}, 0);
        check("R1 rdata", acc_rdata, 0);
        do_read(32'h0000_0024, d);
        check("R1 stored zero", d, 0);
    endtask

    task automatic t_readwrite;
        logic [31:0] d;
        for (int i = 0; i < 16; i++) do_write(32'hE000_0000 | (i << 2), 32'hA500_0000 + i * 32'h111);
        for (int i = 0; i < 16; i += 5) begin
            do_read(32'hE000_0000 | (i << 2), d);
            check("R2 readback", d, model[i]);
        end
    endtask

    task automatic t_flush_untrans;
        xlat_mode = 0;
        do_flush(32'hE123_4560);
        check("R6 busy after accept", {31'd0, busy}, 1);
        check("R4 target buf1", bst_addr, exp_tgt(32'hE123_4560, 0));
        check_payload("R3 buf1 payload", 1);
        @(negedge clk);
        check("R6 held without ack", {31'd0, bst_valid}, 1);
        do_ack();
        check("R6 cleared after ack", {31'd0, busy}, 0);
        do_flush(32'hE3FF_FFC4);
        check("R4 target buf0", bst_addr, exp_tgt(32'hE3FF_FFC4, 0));
        check_payload("R3 buf0 payload", 0);
        do_ack();
    endtask

    task automatic t_flush_xlat;
        xlat_mode = 1;
        do_flush(32'hFBCD_EF7F);
        check("R5 translated target", bst_addr, 32'h1BCD_EF60);
        check_payload("R3 translated payload", 1);
        do_ack();
        xlat_mode = 0;
    endtask

    task automatic t_qaddr_bits;
        qaddr0 = 32'hFFFF_FFE3;
        do_flush(32'h0000_0040);
        check("R9 stray qaddr0 bits", bst_addr, 32'h0000_0040);
        do_ack();
        qaddr0 = 32'h0000_001C;
        do_flush(32'h0000_0040);
        check("R9 qaddr0 [4:2]", bst_addr, 32'h1C00_0040);
        do_ack();
        qaddr0 = 32'h0000_0014;
    endtask

    task automatic t_busy_ignore;
        do_flush(32'hE000_0000);
        do_flush(32'hE0AB_CD20);
        check("R7 addr unchanged", bst_addr, exp_tgt(32'hE000_0000, 0));
        check_payload("R7 payload unchanged", 0);
        do_ack();
        @(negedge clk);
        check("R7 no second burst", {31'd0, bst_valid}, 0);
    endtask

    task automatic t_stall;
        logic [31:0] d;
        do_flush(32'hE000_0020);
        @(negedge clk);
        acc_en = 1; acc_we = 1; acc_addr = 32'hE000_0028; acc_wdata = 32'hDEAD_0001;
        #1 check("R8 stall on flushing buffer", {31'd0, acc_stall}, 1);
        @(negedge clk);
        acc_addr = 32'hE000_0008; acc_wdata = 32'hBEEF_0002;
        #1 check("R8 no stall other buffer", {31'd0, acc_stall}, 0);
        @(negedge clk);
        acc_en = 0; acc_we = 0;
        model[2] = 32'hBEEF_0002;
        check_payload("R8 payload untouched", 1);
        do_ack();
        do_read(32'hE000_0028, d);
        check("R8 stalled write dropped", d, model[10]);
        do_read(32'hE000_0008, d);
        check("R8 other write stored", d, 32'hBEEF_0002);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        flush_req = 1; flush_addr = 32'hE000_0000;
        acc_en = 1; acc_we = 1; acc_addr = 32'hE000_000C; acc_wdata = 32'h5A5A_1234;
        #1 check("R10 no stall on accept cycle", {31'd0, acc_stall}, 0);
        @(negedge clk);
        flush_req = 0; acc_en = 0; acc_we = 0;
        model[3] = 32'h5A5A_1234;
        check("R10 word in burst", bst_data[3*32 +: 32], 32'h5A5A_1234);
        check_payload("R10 full payload", 0);
        do_ack();
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; acc_en = 0; acc_we = 0; acc_addr = 0; acc_wdata = 0;
        flush_req = 0; flush_addr = 0; xlat_mode = 0; bst_ack = 0;
        qaddr0 = 32'h0000_0014; qaddr1 = 32'h0000_0008;
        for (int i = 0; i < 16; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_readwrite();
        t_flush_untrans();
        t_flush_xlat();
        t_qaddr_bits();
        t_busy_ignore();
        t_stall();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule